// File: doc/BRIEF.md
# Buffered Two-Register PWM Generator

This block makes pulse-width-modulated waveforms from a 16-bit up-counter whose period comes from a modulo register. Two compare registers, A and B, set pulse widths. Left unlinked, each one drives its own output pin. When linked, the pair works as one buffered channel on pin A. Software writes new widths into whichever register is idle. The hardware moves to that register at the next counter overflow, so the waveform never shows a truncated or doubled pulse. While the pair is linked, pin B is released for general-purpose use.

A single write port programs the block. The intended setup order is: halt the counter and clear it, load the modulo value, load the compare value(s), then release the halt.

The timer has two states. TMR_HALT is entered by writing the halt bit as 1 and TMR_RUN by writing it as 0. Each channel waveform has two states: WV_HIGH, entered on overflow or on a counter clear, and WV_LOW, entered when the counter matches the compare value. The source selector has three states:
- SEL_SOLO (unlinked) goes to SEL_A when the link bit is set.
- SEL_A goes to SEL_B at an overflow when B was written last.
- SEL_B goes to SEL_A at an overflow when A was written last.
- Both SEL_A and SEL_B return to SEL_SOLO when the link bit is cleared.

Top module: `bpwm_top`

## Requirements
- R1: After reset the timer is in TMR_HALT, the modulo register is all ones, both compare registers are zero, link and both enables are off, and pin_a_o, pin_b_o, ovf_o and release_o are low.
- R2: Write port map, taking effect at the clock edge where wr_en is high:
  - address 0 is timer control: bit 0 halt, bit 1 counter clear.
  - address 1 is the modulo register.
  - address 2 is compare A.
  - address 3 is compare B.
  - address 4 is channel A control: bit 0 output enable, bit 1 link.
  - address 5 is channel B control: bit 0 output enable.
  - address 6 writes the same data to both compare registers.
  - address 7 is ignored.
- R3: While running, the counter steps from 0 to the modulo value and wraps to 0, giving a period of modulo+1 cycles. ovf_o is high for exactly the one cycle in which the counter holds 0 after a wrap.
- R4: A write with the clear bit set zeroes the counter at that edge and starts a new period with the waveform high, without raising ovf_o. The bit is not kept, so a running counter carries on counting from the next cycle.
- R5: While halted, the counter and both pins hold their values and ovf_o stays low.
- R6: A channel's waveform is high from the overflow cycle through the cycle in which the counter equals its compare value, and low for the rest of the period. A compare value at or above the modulo value gives a constant high level, and a compare value of 0 gives one high cycle.
- R7: Unlinked, pin_a_o follows compare A gated by enable A, pin_b_o follows compare B gated by enable B, and release_o is low.
- R8: Linked, release_o is high, pin_b_o is low, and channel B control has no effect. Compare A is the active source right after linking, whatever was written while unlinked.
- R9: A write to the inactive compare register leaves the current period unchanged and takes over from the next overflow.
- R10: At each overflow the active source becomes the compare register written most recently. With no new writes, the source stays as it is.
- R11: A write to the active compare register changes the width within the current period.
- R12: An address 6 write counts B as the most recently written register.
- R13: Compare writes made while halted still update the most-recent-write tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| pin_a_o | output | 1 | Channel A (buffered when linked) PWM output |
| pin_b_o | output | 1 | Channel B PWM output, low while linked |
| ovf_o | output | 1 | One-cycle pulse on counter wrap |
| release_o | output | 1 | High while pin B is free for general-purpose use |

## Verification
Some rules are checked by the assertions on every cycle:
- an overflow only occurs with the counter at zero;
- a halted counter holds and raises no overflow;
- a clear zeroes the counter;
- the waveform is high in every overflow cycle;
- the buffered source changes only in an overflow cycle;
- linking always starts on register A;
- pin B stays quiet while it is released.

The pulse widths themselves need the bench's scenarios. It sweeps modulo 0 to 5 against compare 0 to 7, then runs sequences that show which register drives each period. These sequences cover writes to the inactive and the active register, the dual write, tracking while halted, and the clear bit.

// File: rtl/bpwm_pkg.sv
`timescale 1ns/1ps
package bpwm_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_TMR   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MOD   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CMPA  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CMPB  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CTLA  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CTLB  = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_CMPAB = 3'd6;

    localparam int TMR_HALT_BIT = 0;
    localparam int TMR_CLR_BIT  = 1;
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_LINK_BIT = 1;

    typedef enum logic {TMR_HALT, TMR_RUN} tmr_state_e;
    typedef enum logic {WV_LOW, WV_HIGH} wave_state_e;
    typedef enum logic [1:0] {SEL_SOLO, SEL_A, SEL_B} sel_state_e;

endpackage

// File: rtl/bpwm_regs.sv
`timescale 1ns/1ps
module bpwm_regs
    import bpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  mod_o,
    output logic [CNT_W-1:0]  cmp_a_o,
    output logic [CNT_W-1:0]  cmp_b_o,
    output logic              en_a_o,
    output logic              en_b_o,
    output logic              link_o,
    output logic              tmr_wr_o,
    output logic              tmr_halt_o,
    output logic              tmr_clr_o,
    output logic              cmpa_wr_o,
    output logic              cmpb_wr_o
);

    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] cmp_a_q;
    logic [CNT_W-1:0] cmp_b_q;
    logic             en_a_q;
    logic             en_b_q;
    logic             link_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q   <= '1;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
            en_a_q  <= 1'b0;
            en_b_q  <= 1'b0;
            link_q  <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_MOD:   mod_q   <= wr_data;
                ADR_CMPA:  cmp_a_q <= wr_data;
                ADR_CMPB:  cmp_b_q <= wr_data;
                ADR_CMPAB: begin
                    cmp_a_q <= wr_data;
                    cmp_b_q <= wr_data;
                end
                ADR_CTLA: begin
                    en_a_q <= wr_data[CTL_EN_BIT];
                    link_q <= wr_data[CTL_LINK_BIT];
                end
                ADR_CTLB:  en_b_q  <= wr_data[CTL_EN_BIT];
                default: ;
            endcase
        end
    end

    always_comb begin
        tmr_wr_o   = wr_en && (wr_addr == ADR_TMR);
        tmr_halt_o = wr_data[TMR_HALT_BIT];
        tmr_clr_o  = tmr_wr_o && wr_data[TMR_CLR_BIT];
        cmpa_wr_o  = wr_en && (wr_addr == ADR_CMPA || wr_addr == ADR_CMPAB);
        cmpb_wr_o  = wr_en && (wr_addr == ADR_CMPB || wr_addr == ADR_CMPAB);
    end

    assign mod_o   = mod_q;
    assign cmp_a_o = cmp_a_q;
    assign cmp_b_o = cmp_b_q;
    assign en_a_o  = en_a_q;
    assign en_b_o  = en_b_q;
    assign link_o  = link_q;

endmodule

// File: rtl/bpwm_counter.sv
`timescale 1ns/1ps
module bpwm_counter
    import bpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_wr,
    input  logic             tmr_halt,
    input  logic             clr,
    input  logic [CNT_W-1:0] mod,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             wrap_o,
    output logic             ovf_o
);

    tmr_state_e       state_q;
    tmr_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    // timer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMR_HALT;
        else        state_q <= state_d;
    end

    // next state: any timer-control write sets the state from its halt bit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_HALT: if (tmr_wr && !tmr_halt) state_d = TMR_RUN;
            TMR_RUN:  if (tmr_wr && tmr_halt)  state_d = TMR_HALT;
            default:  state_d = TMR_HALT;
        endcase
    end

    // outputs of the timer state
    always_comb begin
        run_o  = (state_q == TMR_RUN);
        wrap_o = run_o && !clr && (cnt_q == mod);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wrap_o;
            if (clr)         cnt_q <= '0;
            else if (wrap_o) cnt_q <= '0;
            else if (run_o)  cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

endmodule

// File: rtl/bpwm_sel.sv
`timescale 1ns/1ps
module bpwm_sel
    import bpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link,
    input  logic cmpa_wr,
    input  logic cmpb_wr,
    input  logic wrap,
    output logic sel_b_o,
    output logic linked_o
);

    sel_state_e state_q;
    sel_state_e state_d;
    logic       last_b_q;
    logic       last_b_eff;

    // B wins when both registers are written together
    always_comb begin
        if (cmpb_wr)      last_b_eff = 1'b1;
        else if (cmpa_wr) last_b_eff = 1'b0;
        else              last_b_eff = last_b_q;
    end

    // state register and write tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SEL_SOLO;
            last_b_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SEL_SOLO) last_b_q <= 1'b0;
            else                     last_b_q <= last_b_eff;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_SOLO: if (link) state_d = SEL_A;
            SEL_A: begin
                if (!link)                   state_d = SEL_SOLO;
                else if (wrap && last_b_eff) state_d = SEL_B;
            end
            SEL_B: begin
                if (!link)                    state_d = SEL_SOLO;
                else if (wrap && !last_b_eff) state_d = SEL_A;
            end
            default: state_d = SEL_SOLO;
        endcase
    end

    // outputs
    always_comb begin
        sel_b_o  = (state_q == SEL_B);
        linked_o = (state_q != SEL_SOLO);
    end

endmodule

// File: rtl/bpwm_wave.sv
`timescale 1ns/1ps
module bpwm_wave
    import bpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wrap,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             wave_o
);

    wave_state_e state_q;
    wave_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WV_LOW;
        else        state_q <= state_d;
    end

    // overflow and clear outrank the compare match
    always_comb begin
        state_d = state_q;
        if (clr || wrap) begin
            state_d = WV_HIGH;
        end else begin
            unique case (state_q)
                WV_HIGH: if (run && cnt == cmp) state_d = WV_LOW;
                WV_LOW:  state_d = WV_LOW;
                default: state_d = WV_LOW;
            endcase
        end
    end

    always_comb wave_o = (state_q == WV_HIGH);

endmodule

// File: rtl/bpwm_top.sv
`timescale 1ns/1ps
module bpwm_top
    import bpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pin_a_o,
    output logic              pin_b_o,
    output logic              ovf_o,
    output logic              release_o
);

    localparam int NCH = 2;

    logic [CNT_W-1:0] mod_w;
    logic [CNT_W-1:0] cmp_a_w;
    logic [CNT_W-1:0] cmp_b_w;
    logic             en_a_w;
    logic             en_b_w;
    logic             link_w;
    logic             tmr_wr_w;
    logic             tmr_halt_w;
    logic             clr_w;
    logic             cmpa_wr_w;
    logic             cmpb_wr_w;
    logic [CNT_W-1:0] cnt_q;
    logic             run_w;
    logic             wrap_w;
    logic             ovf_w;
    logic             sel_b_w;
    logic             linked_w;
    logic [CNT_W-1:0] cmp_sel [NCH];
    logic [NCH-1:0]   wave_w;

    bpwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .mod_o      (mod_w),
        .cmp_a_o    (cmp_a_w),
        .cmp_b_o    (cmp_b_w),
        .en_a_o     (en_a_w),
        .en_b_o     (en_b_w),
        .link_o     (link_w),
        .tmr_wr_o   (tmr_wr_w),
        .tmr_halt_o (tmr_halt_w),
        .tmr_clr_o  (clr_w),
        .cmpa_wr_o  (cmpa_wr_w),
        .cmpb_wr_o  (cmpb_wr_w)
    );

    bpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_wr   (tmr_wr_w),
        .tmr_halt (tmr_halt_w),
        .clr      (clr_w),
        .mod      (mod_w),
        .cnt_o    (cnt_q),
        .run_o    (run_w),
        .wrap_o   (wrap_w),
        .ovf_o    (ovf_w)
    );

    bpwm_sel u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .link     (link_w),
        .cmpa_wr  (cmpa_wr_w),
        .cmpb_wr  (cmpb_wr_w),
        .wrap     (wrap_w),
        .sel_b_o  (sel_b_w),
        .linked_o (linked_w)
    );

    // channel 0 takes the active register while linked, channel 1 always B
    always_comb begin
        cmp_sel[0] = (linked_w && sel_b_w) ? cmp_b_w : cmp_a_w;
        cmp_sel[1] = cmp_b_w;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        bpwm_wave #(.CNT_W(CNT_W)) u_wave (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_w),
            .wrap   (wrap_w),
            .clr    (clr_w),
            .cnt    (cnt_q),
            .cmp    (cmp_sel[ch]),
            .wave_o (wave_w[ch])
        );
    end

    assign pin_a_o   = en_a_w && wave_w[0];
    assign pin_b_o   = !linked_w && en_b_w && wave_w[1];
    assign ovf_o     = ovf_w;
    assign release_o = linked_w;

endmodule

// File: rtl/bpwm_checker.sv
`timescale 1ns/1ps
module bpwm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             run,
    input logic             clr,
    input logic             ovf,
    input logic             rel,
    input logic             pin_b,
    input logic             sel_b,
    input logic             linked,
    input logic             wave_a
);

    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (cnt == '0)); // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !ovf)); // R4

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt)); // R5

    AST_HALT_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !ovf); // R5

    AST_HIGH_AT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> wave_a); // R6

    AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> !pin_b); // R8

    AST_LINK_STARTS_A: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(linked) |-> !sel_b); // R8

    AST_SWAP_AT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && $past(linked) && (sel_b != $past(sel_b))) |-> ovf); // R10

endmodule

bind bpwm_top bpwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (cnt_q),
    .run    (run_w),
    .clr    (clr_w),
    .ovf    (ovf_o),
    .rel    (release_o),
    .pin_b  (pin_b_o),
    .sel_b  (sel_b_w),
    .linked (linked_w),
    .wave_a (wave_w[0])
);

// File: tb/test_bpwm_top.sv
`timescale 1ns/1ps
module test_bpwm_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = 3'd0;
    logic [W-1:0] wr_data = '0;
    logic         pin_a_o;
    logic         pin_b_o;
    logic         ovf_o;
    logic         release_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bpwm_top #(.CNT_W(W)) i_bpwm_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pin_a_o   (pin_a_o),
        .pin_b_o   (pin_b_o),
        .ovf_o     (ovf_o),
        .release_o (release_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = W'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // measures one full period starting at the next overflow cycle,
    // optionally issuing a write in that first cycle
    task automatic run_period(input bit dow, input logic [2:0] a, input int d,
                              input int m, output int ha, output int hb,
                              output int no);
        @(negedge clk);
        while (!ovf_o) @(negedge clk);
        ha = 0; hb = 0; no = 0;
        if (dow) begin
            wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        end
        for (int k = 0; k <= m; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 1) wr_en = 1'b0;
            ha += int'(pin_a_o);
            hb += int'(pin_b_o);
            no += int'(ovf_o);
        end
        wr_en = 1'b0;
    endtask

    task automatic setup(input int m, input int ca);
        wr(3'd0, 3);   // halt + clear
        wr(3'd1, m);
        wr(3'd2, ca);
        wr(3'd0, 0);   // run
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int ha, hb, no, n, p0, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_a", int'(pin_a_o), 0);
        chk("R1 pin_b", int'(pin_b_o), 0);
        chk("R1 ovf", int'(ovf_o), 0);
        chk("R1 release", int'(release_o), 0);
        // R1 timer starts halted: short period, no overflow appears
        wr(3'd1, 1);
        wr(3'd4, 1);
        no = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            no += int'(ovf_o);
        end
        chk("R1 halted after reset ovf count", no, 0);
        chk("R1 pin_a low after reset", int'(pin_a_o), 0);

        // R3 / R6 sweep, unlinked channel A
        for (int m = 0; m <= 5; m++) begin
            for (int c = 0; c <= 7; c++) begin
                setup(m, c);
                run_period(1'b0, 3'd0, 0, m, ha, hb, no);
                chk($sformatf("R6 width m=%0d c=%0d", m, c), ha,
                    ((c < m) ? c : m) + 1);
                chk($sformatf("R3 ovf per period m=%0d", m), no, 1);
                @(negedge clk);
                chk($sformatf("R3 next ovf m=%0d", m), int'(ovf_o), 1);
            end
        end

        // R7 unlinked pin B
        setup(7, 1);
        wr(3'd3, 3);
        wr(3'd5, 1);
        run_period(1'b0, 3'd0, 0, 7, ha, hb, no);
        chk("R7 pin_a width", ha, 2);
        chk("R7 pin_b width", hb, 4);
        chk("R7 release low", int'(release_o), 0);
        wr(3'd5, 0);
        run_period(1'b0, 3'd0, 0, 7, ha, hb, no);
        chk("R7 pin_b gated by enable", hb, 0);
        wr(3'd5, 1);

        // R8 link: A active first despite earlier B write
        wr(3'd2, 2);
        wr(3'd4, 3);
        run_period(1'b0, 3'd0, 0, 7, ha, hb, no);
        chk("R8 linked starts on A", ha, 3);
        chk("R8 pin_b quiet", hb, 0);
        chk("R8 release high", int'(release_o), 1);
        wr(3'd5, 1);
        run_period(1'b0, 3'd0, 0, 7, ha, hb, no);
        chk("R10 source stays A without writes", ha, 3);
        chk("R8 channel B control ignored", hb, 0);

        // R9 write inactive B
        run_period(1'b1, 3'd3, 5, 7, ha, hb, no);
        chk("R9 current period unchanged", ha, 3);
        run_period(1'b0, 3'd0, 0, 7, ha, hb, no);
        chk("R9 B takes over at overflow", ha, 6);
        run_period(1'b0, 3'd0, 0, 7, ha, hb, no);
        chk("R10 B stays active", ha, 6);

        // R11 write active B
        run_period(1'b1, 3'd3, 1, 7, ha, hb, no);
        chk("R11 active write immediate", ha, 2);
        run_period(1'b0, 3'd0, 0, 7, ha, hb, no);
        chk("R11 active value kept", ha, 2);

        // R9/R10 back to A
        run_period(1'b1, 3'd2, 3, 7, ha, hb, no);
        chk("R9 A write leaves B period", ha, 2);
        run_period(1'b0, 3'd0, 0, 7, ha, hb, no);
        chk("R10 A active after overflow", ha, 4);

        // R12 dual write: B counts as last
        run_period(1'b1, 3'd6, 4, 7, ha, hb, no);
        chk("R12 dual write hits active A", ha, 5);
        run_period(1'b1, 3'd3, 1, 7, ha, hb, no);
        chk("R12 B active after dual write", ha, 2);

        // R5 halt hold, R13 tracking while halted
        wr(3'd0, 1);
        p0 = int'(pin_a_o);
        bad = 0; no = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (int'(pin_a_o) != p0) bad++;
            no += int'(ovf_o);
        end
        chk("R5 pin holds while halted", bad, 0);
        chk("R5 no ovf while halted", no, 0);
        wr(3'd2, 5);
        wr(3'd0, 0);
        run_period(1'b0, 3'd0, 0, 7, ha, hb, no);
        chk("R13 halted write tracked", ha, 6);

        // R4 clear while running
        wr(3'd0, 2);
        chk("R4 pin high after clear", int'(pin_a_o), 1);
        chk("R4 no ovf on clear", int'(ovf_o), 0);
        n = 0;
        while (!ovf_o) begin
            @(negedge clk);
            n++;
        end
        chk("R4 counting resumes, cycles to ovf", n, 8);

        // R2 address 7 ignored
        wr(3'd7, 0);
        run_period(1'b0, 3'd0, 0, 7, ha, hb, no);
        chk("R2 address 7 no effect", ha, 6);

        // R7 unlink again
        wr(3'd4, 1);
        @(negedge clk);
        chk("R7 release low after unlink", int'(release_o), 0);
        run_period(1'b0, 3'd0, 0, 7, ha, hb, no);
        chk("R7 pin_a from A after unlink", ha, 6);
        chk("R7 pin_b from B after unlink", hb, 2);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule